// File: doc/BRIEF.md
# Stereo Playback Sample Buffer

This block sits between a processor write port and a codec that asks for audio one stereo frame at a time. The processor writes 16-bit samples one per cycle. The samples alternate left and right, and the first sample after reset or after a buffer clear is a left sample. When the codec pulses its request input, the block removes the two oldest entries, left first and then right. It presents both on parallel outputs together with a one-cycle valid strobe. The buffer holds sixteen entries, which is eight stereo frames. It reports its occupancy and full, empty and nearly-empty flags, and it drives a level interrupt whose fullness threshold can be picked from four values.

A request that finds fewer than two stored entries is an underrun. The block then outputs a zero frame and sets a sticky error flag. A small state machine holds that flag. In state ST_RUN the error is low. The transition "underrun" moves it to ST_FAULT, where the error is high. In ST_FAULT, writes and pops still work, but the flag stays set. Only the transition "clear", taken when the dedicated buffer-clear input is pulsed, returns it to ST_RUN, and the same pulse also empties the buffer. The asynchronous reset also puts the machine in ST_RUN. Both ports share one clock.

Top module: `stereo_play_buf`

## Requirements
- R1: After reset, `level` is 0, `empty` and `near_empty` are 1, and `full`, `underrun_err` and `pair_valid` are 0. The first sample written after a reset or a clear comes out on `left_out`.
- R2: A write with `wr_en` high while `full` is low stores `wr_data` in arrival order and raises `level` by one on the next clock.
- R3: `full` is 1 exactly when `level` is 16. A write while `full` is 1 is dropped: it changes neither `level` nor any stored sample.
- R4: A `pair_req` while `level` is at least 2 gives `pair_valid` high in the following cycle, with `left_out` holding the oldest entry and `right_out` the next one. `level` drops by two.
- R5: A `pair_req` while `level` is below 2 is an underrun. In the following cycle `pair_valid` is high with `left_out` and `right_out` both zero, and `underrun_err` is 1. `level` is unchanged and no entry is removed.
- R6: Once set, `underrun_err` stays 1 through writes and pops until `fifo_clr` is pulsed. One cycle after `fifo_clr`, `underrun_err` is 0 and `level` is 0. `fifo_clr` takes priority over a write or request in the same cycle.
- R7: `irq` is 1 while `level` is at most `thresh_sel` × 4. The encodings are 00 for empty only, 01 for at most 4, 10 for at most 8, and 11 for at most 12.
- R8: `empty` is 1 exactly when `level` is 0, and `near_empty` is 1 exactly when `level` is below 2, so that a frame cannot be supplied.
- R9: A write and a request in the same cycle, with `level` at least 2 and below 16, leave `level` one lower than before.
- R10: `pair_valid` is high for exactly one cycle per request cycle and is 0 in any cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous buffer clear; empties storage and clears the error |
| wr_en | input | 1 | Processor sample write strobe |
| wr_data | input | 16 | Sample to store |
| thresh_sel | input | 2 | Interrupt fullness threshold select |
| pair_req | input | 1 | Codec request for one stereo frame |
| left_out | output | 16 | Left sample of the delivered frame |
| right_out | output | 16 | Right sample of the delivered frame |
| pair_valid | output | 1 | One-cycle strobe marking a delivered frame |
| level | output | 5 | Stored entry count, 0 to 16 |
| full | output | 1 | Buffer holds 16 entries |
| empty | output | 1 | Buffer holds no entries |
| near_empty | output | 1 | Fewer than two entries stored |
| irq | output | 1 | Level interrupt: occupancy at or below the threshold |
| underrun_err | output | 1 | Sticky underrun error |

## Verification
The frame path is tested with distinct ascending values, so a swapped channel, a lost sample or a repeated sample shows up as a wrong value in the scoreboard. Filling the buffer and then writing a marker value tells a dropped write apart from one that overwrites the oldest entry. A write and a request in the same cycle test the net count update. Requests on an empty buffer and on a buffer holding one entry separate the underrun path from the normal pop. A clear after the underrun shows that left/right alignment is restored and that the error goes away only through the clear. Each interrupt threshold is sampled on both sides of its limit.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } fault_state_t;
endpackage

// File: rtl/spb_store.sv
module spb_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/spb_ctrl.sv
module spb_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_req,
    input  logic          pop_req,
    output logic          wr_acc,
    output logic          pop_ok,
    output logic          under,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          is_full,
    output logic          is_empty
);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
    localparam logic [CW-1:0] PAIR_CNT = CW'(2);

    assign is_full  = (count == CNT_MAX);
    assign is_empty = (count == '0);
    assign wr_acc   = wr_req && !is_full && !clr;
    assign pop_ok   = pop_req && (count >= PAIR_CNT) && !clr;
    assign under    = pop_req && (count < PAIR_CNT) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_acc) begin
                wptr <= wptr + AW'(1);
            end
            if (pop_ok) begin
                rptr <= rptr + AW'(2);
            end
            count <= count + CW'(wr_acc) - (pop_ok ? PAIR_CNT : '0);
        end
    end
endmodule

// File: rtl/spb_fault_fsm.sv
module spb_fault_fsm
    import spb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic under,
    output logic err
);
    fault_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (under) state_nx = ST_FAULT;
            ST_FAULT: if (clr)   state_nx = ST_RUN;
            default:             state_nx = ST_RUN;
        endcase
        if (clr) begin
            state_nx = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN:   err = 1'b0;
            ST_FAULT: err = 1'b1;
            default:  err = 1'b0;
        endcase
    end
endmodule

// File: rtl/spb_status.sv
module spb_status #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    sel,
    output logic          irq,
    output logic          near_empty
);
    localparam int QTR = DEPTH / 4;

    logic [CW-1:0] limits [4];

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign limits[g] = CW'(g * QTR);
    end

    assign irq        = (count <= limits[sel]);
    assign near_empty = (count < CW'(2));
endmodule

// File: rtl/stereo_play_buf.sv
module stereo_play_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    thresh_sel,
    input  logic          pair_req,
    output logic [DW-1:0] left_out,
    output logic [DW-1:0] right_out,
    output logic          pair_valid,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          near_empty,
    output logic          irq,
    output logic          underrun_err
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_acc, pop_ok, under;
    logic [AW-1:0] wptr, rptr;
    logic [DW-1:0] rd_l, rd_r;

    spb_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(LW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .wr_req   (wr_en),
        .pop_req  (pair_req),
        .wr_acc   (wr_acc),
        .pop_ok   (pop_ok),
        .under    (under),
        .wptr     (wptr),
        .rptr     (rptr),
        .count    (level),
        .is_full  (full),
        .is_empty (empty)
    );

    spb_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .we      (wr_acc),
        .waddr   (wptr),
        .wdata   (wr_data),
        .raddr_a (rptr),
        .raddr_b (rptr + AW'(1)),
        .rdata_a (rd_l),
        .rdata_b (rd_r)
    );

    spb_fault_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .under (under),
        .err   (underrun_err)
    );

    spb_status #(.DEPTH(DEPTH), .CW(LW)) u_stat (
        .count      (level),
        .sel        (thresh_sel),
        .irq        (irq),
        .near_empty (near_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
            left_out   <= '0;
            right_out  <= '0;
        end else begin
            pair_valid <= pop_ok || under;
            if (pop_ok) begin
                left_out  <= rd_l;
                right_out <= rd_r;
            end else if (under) begin
                left_out  <= '0;
                right_out <= '0;
            end
        end
    end
endmodule

// File: rtl/spb_chk.sv
module spb_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          pair_req,
    input logic [DW-1:0] left_out,
    input logic [DW-1:0] right_out,
    input logic          pair_valid,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          underrun_err
);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    // R3
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !pair_req && !fifo_clr |=> full);

    // R4
    pair_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_req && !fifo_clr && int'(level) >= 2 |=>
        pair_valid && (int'(level) == int'($past(level)) - 2 + int'($past(wr_en && !full))));

    // R5
    underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_req && !fifo_clr && int'(level) < 2 |=>
        pair_valid && underrun_err && left_out == '0 && right_out == '0);

    // R6
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err && !fifo_clr |=> underrun_err);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> level == '0 && !underrun_err);

    // R8
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R10
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_req |=> !pair_valid);
endmodule

bind stereo_play_buf spb_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_clr     (fifo_clr),
    .wr_en        (wr_en),
    .pair_req     (pair_req),
    .left_out     (left_out),
    .right_out    (right_out),
    .pair_valid   (pair_valid),
    .level        (level),
    .full         (full),
    .empty        (empty),
    .underrun_err (underrun_err)
);

// File: tb/sim_stereo_play_buf.sv
`timescale 1ns/1ps
module sim_stereo_play_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  thresh_sel = 2'b00;
    logic        pair_req = 1'b0;
    logic [15:0] left_out, right_out;
    logic        pair_valid;
    logic [4:0]  level;
    logic        full, empty, near_empty, irq, underrun_err;

    int checks = 0;
    int errors = 0;
    logic [15:0] mq [$];
    logic [15:0] exp_l [$];
    logic [15:0] exp_r [$];
    bit finished = 0;

    always #4 clk = ~clk;

    stereo_play_buf u0 (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .wr_en(wr_en),
        .wr_data(wr_data), .thresh_sel(thresh_sel), .pair_req(pair_req),
        .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid),
        .level(level), .full(full), .empty(empty), .near_empty(near_empty),
        .irq(irq), .underrun_err(underrun_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        if (mq.size() < 16) mq.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic model_req();
        if (mq.size() >= 2) begin
            exp_l.push_back(mq.pop_front());
            exp_r.push_back(mq.pop_front());
        end else begin
            exp_l.push_back(16'h0);
            exp_r.push_back(16'h0);
        end
    endtask

    task automatic request();
        @(negedge clk);
        pair_req = 1'b1;
        model_req();
        @(negedge clk);
        pair_req = 1'b0;
    endtask

    task automatic push_and_req(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; pair_req = 1'b1;
        model_req();
        if (mq.size() < 16) mq.push_back(d);
        @(negedge clk);
        wr_en = 1'b0; pair_req = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        fifo_clr = 1'b1;
        mq.delete();
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic lvl(input int e, input string req);
        chk(int'(level) == e, req, int'(level), e);
    endtask

    // scoreboard monitor: R4, R5, R10
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && pair_valid) begin
                if (exp_l.size() == 0) begin
                    chk(1'b0, "R10 unexpected pair_valid", 1, 0);
                end else begin
                    logic [15:0] el, er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    chk(left_out == el, "R4/R5 left_out", left_out, el);
                    chk(right_out == er, "R4/R5 right_out", right_out, er);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        lvl(0, "R1 level");
        chk(empty && near_empty, "R1 empty flags", {empty, near_empty}, 3);
        chk(!full && !underrun_err && !pair_valid, "R1 full/err/valid", {full, underrun_err, pair_valid}, 0);
        chk(irq == 1'b1, "R7 sel00 at empty", irq, 1);

        // R2 writes
        for (int i = 0; i < 6; i++) push(16'h0100 + 16'(i));
        lvl(6, "R2 level after 6 writes");
        chk(!near_empty && !empty, "R8 flags at 6", {near_empty, empty}, 0);
        thresh_sel = 2'b01; #1;
        chk(irq == 1'b0, "R7 sel01 at 6", irq, 0);
        thresh_sel = 2'b10; #1;
        chk(irq == 1'b1, "R7 sel10 at 6", irq, 1);

        // R4 pops
        request();
        request();
        lvl(2, "R4 level after two pops");

        // R3 fill and drop
        for (int i = 0; i < 14; i++) push(16'h0200 + 16'(i));
        lvl(16, "R3 level at capacity");
        chk(full == 1'b1, "R3 full", full, 1);
        push(16'hDEAD);
        lvl(16, "R3 write while full dropped");
        thresh_sel = 2'b11; #1;
        chk(irq == 1'b0, "R7 sel11 at 16", irq, 0);
        request();
        request();
        lvl(12, "R4 level 12");
        chk(irq == 1'b1, "R7 sel11 at 12", irq, 1);
        for (int i = 0; i < 6; i++) request();
        lvl(0, "R4 drained");
        chk(empty == 1'b1 && !underrun_err, "R8 empty after drain", {empty, underrun_err}, 2);

        // R9 simultaneous write and request
        for (int i = 0; i < 3; i++) push(16'h0300 + 16'(i));
        push_and_req(16'h0303);
        lvl(2, "R9 net level");
        request();
        lvl(0, "R4 level zero");

        // R5 underrun on empty
        request();
        @(negedge clk);
        chk(underrun_err == 1'b1, "R5 error set", underrun_err, 1);
        lvl(0, "R5 level unchanged");

        // R6 sticky through traffic
        push(16'h0400); push(16'h0401);
        request();
        chk(underrun_err == 1'b1, "R6 error sticky", underrun_err, 1);

        // R5 underrun with one entry
        push(16'h0500);
        request();
        lvl(1, "R5 single entry kept");
        chk(near_empty == 1'b1, "R8 near_empty at 1", near_empty, 1);

        // R6 clear
        clear();
        lvl(0, "R6 level after clear");
        chk(underrun_err == 1'b0, "R6 error cleared", underrun_err, 0);

        // R1 left alignment after clear
        push(16'h0600); push(16'h0601);
        request();
        repeat (3) @(negedge clk);
        chk(exp_l.size() == 0, "R10 all frames delivered", exp_l.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule